// File: doc/BRIEF.md
# Dual Cascadable Interval Timer

The block holds two 8-bit interval timers that count down from a programmable divider and raise a sticky interrupt each time they underflow. Each timer picks its tick from a set of single-cycle enable strobes: a fast tick supplied at a port, a slow tick supplied at a port, or a prescaled tick that a free-running prescaler produces from the fast tick. The second timer may instead be cascaded, so that it counts the first timer's underflows. With a 25 kHz tick and a divider of 250, timer 0 interrupts at 100 Hz.

One write port carries the whole control word. In one write, each timer gets a divider, a tick select, a mode and an interrupt action. In the stop-and-load mode a timer holds still and its count takes the divider value. In the run mode it counts. The interrupt action either leaves the pending flag as it is or clears it. A combinational read port returns either timer count, the prescaler status or the two pending flags. Software reads the prescaler status to get a finer time within one timer period. If the timer count changes between two reads, software reads the prescaler again. All pins are plain control and status pins. The write port accepts a word in every cycle that its enable is high, so it has no valid/ready handshake and no back-pressure.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, both timers are in stop-and-load with divider 0 and count 0, both pending flags are 0, and the prescaler status is PRESC_DIV-1.
- R2: A write loads both timers from wr_data_i. Timer 0 takes bits [11:0] and timer 1 takes bits [23:12]. Inside each 12-bit field, [7:0] is the divider, [9:8] is the tick select, [10] is the mode (0 = stop-and-load, 1 = run) and [11] is the interrupt action (0 = leave, 1 = clear).
- R3: A write with mode 0 sets the count to the divider. While a timer is in stop-and-load, its count does not change, whatever ticks arrive.
- R4: In run mode, the count falls by one on each cycle that the selected tick is high, and it stays unchanged on all other cycles.
- R5: When the count is 1 and a selected tick arrives in run mode, the timer underflows. The count reloads from the divider in that same cycle and the pending flag sets. A divider of 0 acts as 256, so the count steps 0, 255, down to 1 and the period is 256 ticks.
- R6: The pending flag stays set until a write with interrupt action 1 clears it. A write with interrupt action 0 leaves it unchanged.
- R7: Timer 0 tick select codes: 0 selects fast_tick_i, 1 selects slow_tick_i, 2 selects the prescaled tick, and 3 selects no tick.
- R8: Timer 1 uses the same codes 0 to 2. Code 3 cascades it from timer 0, so it counts once for each timer 0 underflow, in the same cycle as that underflow.
- R9: The prescaler counts down by one on each fast_tick_i, from PRESC_DIV-1 to 0, and then wraps back to PRESC_DIV-1. The prescaled tick is the fast tick that arrives while the prescaler status is 0. The prescaler runs freely, including in write cycles.
- R10: rd_data_o returns timer 0's count for rd_sel_i = 0, timer 1's count for 1, the prescaler status for 2, and {timer 1 flag, timer 0 flag} in bits [1:0] for 3. irq_o carries the same two flags.
- R11: In a write cycle neither timer counts, even if its selected tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_tick_i | input | 1 | Fast tick strobe; also clocks the prescaler |
| slow_tick_i | input | 1 | Slow fixed-rate tick strobe |
| wr_en_i | input | 1 | Control word write enable |
| wr_data_i | input | 24 | Control word for both timers |
| rd_sel_i | input | 2 | Read select |
| rd_data_o | output | 8 | Read data |
| irq_o | output | 2 | Pending interrupt flags, bit 0 for timer 0 |

## Verification
The bench sweeps every divider value, 0 through 255, on timer 0. A design that mishandled the divider-0 case, or that reloaded one tick too early or too late, would show the wrong count one tick before underflow, or would set the flag at the wrong moment. Further checks cover the cascade and the prescaled and slow selects. A cascade that counted timer 0 ticks instead of its underflows, or a prescaler that wrapped at the wrong value, would give a count that differs from the one the bench computes from its own tick tally. The bench also puts a tick in a write cycle, sends ticks to a stopped timer, and sends writes that leave the flag or clear it. A design that let any of these move the count or the flag would fail there.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int CNT_W = 8;
  localparam int N_TMR = 2;

  typedef enum logic {MODE_STOP_LD = 1'b0, MODE_RUN = 1'b1} mode_e;
  typedef enum logic [1:0] {SEL_FAST = 2'd0, SEL_SLOW = 2'd1,
                            SEL_PRESC = 2'd2, SEL_ALT = 2'd3} sel_e;

  // packed MSB first: action[11], mode[10], sel[9:8], div[7:0]
  typedef struct packed {
    logic             irq_clr;
    mode_e            mode;
    sel_e             sel;
    logic [CNT_W-1:0] div;
  } tmr_cfg_t;

  localparam int CFG_W = $bits(tmr_cfg_t);
endpackage

// File: rtl/dit_prescaler.sv
module dit_prescaler #(
  parameter int PRESC_DIV = 4,
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fast_tick,
  output logic [PW-1:0] status,
  output logic          presc_tick
);
  localparam logic [PW-1:0] TOP = PW'(PRESC_DIV - 1);

  logic [PW-1:0] cnt_q;

  assign presc_tick = fast_tick && (cnt_q == '0);
  assign status     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= TOP;
    else if (fast_tick)  cnt_q <= (cnt_q == '0) ? TOP : cnt_q - 1'b1;
  end
endmodule

// File: rtl/dit_timer.sv
module dit_timer
  import dit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  tmr_cfg_t         cfg,
  input  logic             fast_tick,
  input  logic             slow_tick,
  input  logic             presc_tick,
  input  logic             alt_tick,
  output logic [CNT_W-1:0] count,
  output logic             flag,
  output logic             underflow
);
  logic [CNT_W-1:0] div_q;
  sel_e             sel_q;
  mode_e            mode_q;
  logic             tick;

  always_comb begin
    unique case (sel_q)
      SEL_FAST:  tick = fast_tick;
      SEL_SLOW:  tick = slow_tick;
      SEL_PRESC: tick = presc_tick;
      default:   tick = alt_tick;
    endcase
  end

  assign underflow = !wr_en && (mode_q == MODE_RUN) && tick && (count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      sel_q  <= SEL_FAST;
      mode_q <= MODE_STOP_LD;
      count  <= '0;
      flag   <= 1'b0;
    end else if (wr_en) begin
      div_q  <= cfg.div;
      sel_q  <= cfg.sel;
      mode_q <= cfg.mode;
      if (cfg.mode == MODE_STOP_LD) count <= cfg.div;
      if (cfg.irq_clr) flag <= 1'b0;
    end else if (mode_q == MODE_RUN && tick) begin
      if (count == CNT_W'(1)) begin
        count <= div_q;
        flag  <= 1'b1;
      end else begin
        count <= count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dit_readmux.sv
module dit_readmux
  import dit_pkg::*;
#(
  parameter int PW = 2
) (
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] cnt0,
  input  logic [CNT_W-1:0] cnt1,
  input  logic [PW-1:0]    presc,
  input  logic [1:0]       flags,
  output logic [CNT_W-1:0] data
);
  always_comb begin
    unique case (sel)
      2'd0:    data = cnt0;
      2'd1:    data = cnt1;
      2'd2:    data = CNT_W'(presc);
      default: data = CNT_W'(flags);
    endcase
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int PRESC_DIV = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fast_tick_i,
  input  logic                   slow_tick_i,
  input  logic                   wr_en_i,
  input  logic [N_TMR*CFG_W-1:0] wr_data_i,
  input  logic [1:0]             rd_sel_i,
  output logic [CNT_W-1:0]       rd_data_o,
  output logic [N_TMR-1:0]       irq_o
);
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;

  logic [PW-1:0]    presc_status;
  logic             presc_tick;
  logic [CNT_W-1:0] cnt [N_TMR];
  logic [N_TMR-1:0] flags;
  logic [N_TMR-1:0] uf;

  dit_prescaler #(.PRESC_DIV(PRESC_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick_i),
    .status(presc_status), .presc_tick(presc_tick)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    logic     alt;
    tmr_cfg_t cfg;
    assign cfg = tmr_cfg_t'(wr_data_i[i*CFG_W +: CFG_W]);
    if (i == 0) begin : g_first
      assign alt = 1'b0;
    end else begin : g_casc
      assign alt = uf[i-1];
    end
    dit_timer u_tmr (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .cfg(cfg),
      .fast_tick(fast_tick_i), .slow_tick(slow_tick_i),
      .presc_tick(presc_tick), .alt_tick(alt),
      .count(cnt[i]), .flag(flags[i]), .underflow(uf[i])
    );
  end

  dit_readmux #(.PW(PW)) u_rd (
    .sel(rd_sel_i), .cnt0(cnt[0]), .cnt1(cnt[1]),
    .presc(presc_status), .flags(flags), .data(rd_data_o)
  );

  assign irq_o = flags;
endmodule

// File: rtl/dit_checker.sv
module dit_checker
  import dit_pkg::*;
#(
  parameter int PRESC_DIV = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [23:0]      wr_data,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1,
  input logic [1:0]       flags,
  input logic [1:0]       uf,
  input logic [CNT_W-1:0] presc
);
  logic       run0, run1;
  logic [1:0] sel1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run0 <= 1'b0; run1 <= 1'b0; sel1 <= 2'd0;
    end else if (wr_en) begin
      run0 <= wr_data[10]; run1 <= wr_data[22]; sel1 <= wr_data[21:20];
    end
  end

  a_r3_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !run0) |=> cnt0 == $past(cnt0));
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[10]) |=> cnt0 == $past(wr_data[7:0]));
  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    uf[0] |=> flags[0]);
  a_r6_clear0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[11]) |=> !flags[0]);
  a_r6_clear1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[23]) |=> !flags[1]);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !wr_en) |=> flags[0]);
  a_r8_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && run1 && sel1 == 2'd3 && uf[0] && cnt1 != CNT_W'(1))
      |=> cnt1 == $past(cnt1) - 1'b1);
  a_r11_write_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[10]) |=> cnt0 == $past(cnt0));
  a_r9_presc_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(presc) < PRESC_DIV);
endmodule

bind dual_interval_timer dit_checker #(.PRESC_DIV(PRESC_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_data(wr_data_i),
  .cnt0(cnt[0]), .cnt1(cnt[1]), .flags(flags), .uf(uf),
  .presc(CNT_W'(presc_status))
);

// File: tb/tb_dual_interval_timer.sv
module tb_dual_interval_timer;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fast = 1'b0, slow = 1'b0, wr_en = 1'b0;
  logic [23:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [7:0]  rd_data;
  logic [1:0]  irq;

  int checks = 0, errors = 0, nfast = 0;

  dual_interval_timer #(.PRESC_DIV(P)) dut (
    .clk(clk), .rst_n(rst_n), .fast_tick_i(fast), .slow_tick_i(slow),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [11:0] mk(input int div, input int sel, input bit run, input bit clr);
    return {clr, run, sel[1:0], div[7:0]};
  endfunction

  function automatic int presc_exp();
    return (P - 1) - (nfast % P);
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic rd(input int sel, output int v);
    rd_sel = sel[1:0];
    #1;
    v = int'(rd_data);
  endtask

  task automatic step(input bit f, input bit s);
    fast = f; slow = s;
    @(negedge clk);
    fast = 0; slow = 0;
    if (f) nfast++;
  endtask

  task automatic wr(input logic [11:0] c0, input logic [11:0] c1);
    wr_en = 1; wr_data = {c1, c0};
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, dv, wraps, base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 cnt0", v, 0);
    rd(1, v); chk("R1 cnt1", v, 0);
    rd(2, v); chk("R1 presc", v, P - 1);
    rd(3, v); chk("R1 flags", v, 0);

    // R5 sweep of every divider on timer 0, fast select
    for (int d = 0; d < 256; d++) begin
      dv = (d == 0) ? 256 : d;
      wr(mk(d, 0, 0, 1), mk(0, 0, 0, 1));
      rd(0, v); chk("R2 R3 load", v, d);
      wr(mk(d, 0, 1, 0), mk(0, 0, 0, 0));
      for (int k = 1; k < dv; k++) step(1, 0);
      rd(0, v); chk("R4 before underflow", v, (dv == 1) ? d : 1);
      chk("R5 no early flag", int'(irq[0]), 0);
      step(1, 0);
      rd(0, v); chk("R5 reload", v, d);
      chk("R5 flag", int'(irq[0]), 1);
    end

    // R6 nop keeps flag, clear drops it
    wr(mk(4, 0, 0, 0), mk(0, 0, 0, 0));
    rd(3, v); chk("R6 nop keeps", v, 1);
    step(1, 1);
    chk("R6 sticky", int'(irq[0]), 1);
    wr(mk(4, 0, 0, 1), mk(0, 0, 0, 0));
    rd(3, v); chk("R6 R10 cleared", v, 0);

    // R3 stopped timer ignores ticks
    for (int k = 0; k < 3; k++) step(1, 1);
    rd(0, v); chk("R3 hold", v, 4);

    // R8 cascade: timer0 div 3, timer1 div 2 on underflows
    wr(mk(3, 0, 0, 1), mk(2, 3, 0, 1));
    wr(mk(3, 0, 1, 0), mk(2, 3, 1, 0));
    for (int k = 0; k < 3; k++) step(1, 0);
    rd(1, v); chk("R8 cascade count", v, 1);
    rd(3, v); chk("R8 flags after one", v, 1);
    for (int k = 0; k < 3; k++) step(1, 0);
    rd(1, v); chk("R8 cascade reload", v, 2);
    rd(3, v); chk("R8 R10 flags both", v, 3);
    chk("R10 irq port", int'(irq), 3);

    // R7 slow select
    wr(mk(5, 1, 0, 1), mk(0, 0, 0, 1));
    wr(mk(5, 1, 1, 0), mk(0, 0, 0, 0));
    for (int k = 0; k < 3; k++) step(1, 0);
    rd(0, v); chk("R7 slow ignores fast", v, 5);
    step(0, 1); step(0, 1);
    rd(0, v); chk("R7 slow counts", v, 3);

    // R7 select code 3 on timer 0 gives no tick
    wr(mk(7, 3, 0, 1), mk(0, 0, 0, 1));
    wr(mk(7, 3, 1, 0), mk(0, 0, 0, 0));
    for (int k = 0; k < 4; k++) step(1, 1);
    rd(0, v); chk("R7 none select", v, 7);

    // R9 prescaled select
    rd(2, v); chk("R9 presc status", v, presc_exp());
    wr(mk(10, 2, 0, 1), mk(0, 0, 0, 1));
    wr(mk(10, 2, 1, 0), mk(0, 0, 0, 0));
    wraps = 0;
    base = nfast;
    for (int k = 0; k < 2 * P + 1; k++) begin
      if (((P - 1) - ((base + k) % P)) == 0) wraps++;
      step(1, 0);
    end
    rd(0, v); chk("R9 prescaled count", v, 10 - wraps);
    rd(2, v); chk("R9 presc after", v, presc_exp());

    // R11 tick during write does not count
    wr(mk(9, 0, 0, 1), mk(0, 0, 0, 1));
    wr(mk(9, 0, 1, 0), mk(0, 0, 0, 0));
    step(1, 0);
    rd(0, v); chk("R4 one tick", v, 8);
    fast = 1;
    wr(mk(9, 0, 1, 0), mk(0, 0, 0, 0));
    fast = 0; nfast++;
    rd(0, v); chk("R11 write freeze", v, 8);
    rd(2, v); chk("R9 presc in write", v, presc_exp());

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule